// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is one DMA channel that copies 16-bit words from a source region to a destination region. Software fills a set of configuration inputs: shadow begin and current addresses for each side, the burst and transfer lengths, and three signed steps per side. The within-burst step is applied between words. The between-burst step is applied at burst boundaries. The wrap step is applied when a side's wrap counter expires. A start pulse arms the channel. After that, each peripheral trigger pulse launches one burst. Each word takes a read cycle on the memory port, then a write cycle that forwards the data returned one cycle later.

The controller is a four-state machine:

- `S_IDLE`: the channel is not running. On start, it copies the shadows into the working registers and goes to `S_ARMED`.
- `S_ARMED`: waiting. A trigger, or a pending trigger, moves it to `S_RD`.
- `S_RD`: the read cycle. It always moves to `S_WR`.
- `S_WR`: the write cycle. From here there are four exits:
  - to `S_RD` for the next word of the same burst;
  - to `S_ARMED` at a burst boundary, or straight to `S_RD` in one-shot mode;
  - to `S_ARMED` with the shadows reloaded, at the end of a transfer in continuous mode;
  - to `S_IDLE` at the end of a transfer otherwise.

A trigger that arrives during a burst is kept as one pending flag. The interrupt is a one-cycle pulse. Depending on a mode input, it fires either as the first burst of a transfer launches or right after the final write of the transfer.

Top module: `dma_addr_seq`

## Requirements
- R1: One cycle after a start pulse in `S_IDLE`, `run` is 1 and `busy` stays 0 until a trigger arrives. Start does not launch a burst by itself.
- R2: With one-shot off, each accepted trigger moves exactly `cfg_blen`+1 words. Each word is one cycle with `mem_rd_en`=1 at the source address, then one cycle with `mem_wr_en`=1 at the destination address. The write data is the word returned on `mem_rd_data` one cycle after the read.
- R3: Inside a burst, the within-burst step is added to each side's address between consecutive words only.
- R4: At a burst boundary where a side's wrap counter is non-zero, that side's address advances by its between-burst step and the counter decrements.
- R5: Each side's wrap counter is loaded from its wrap-size input at start. When it is zero at a burst boundary, the between-burst step is skipped: the begin address advances by the wrap step, the current address takes the new begin value, and the counter reloads. Source and destination wrap independently.
- R6: A transfer ends after `cfg_xlen`+1 bursts. With continuous mode off, `run` then falls to 0 and later triggers cause no memory access.
- R7: With continuous mode on, the end of a transfer reloads the shadow addresses and both counters. `run` stays 1, and the next transfer restarts from the shadow values.
- R8: Any number of triggers during a burst collapse into one pending flag. That flag launches exactly one further burst.
- R9: With `cfg_irq_at_end`=1, `irq` is a one-cycle pulse in the cycle right after the final write of a transfer. With it 0, `irq` pulses once per transfer, in the cycle after the first burst launches.
- R10: With one-shot on, one trigger runs every burst of the transfer back to back.
- R11: Steps are 16-bit two's complement, sign-extended and added to 22-bit addresses modulo 2^22.
- R12: After reset, `run`, `busy`, `irq`, `mem_rd_en` and `mem_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the channel from idle, copying the shadows |
| trig | input | 1 | Peripheral trigger pulse, one burst each |
| cfg_src_beg_sh | input | 22 | Source begin-address shadow |
| cfg_src_cur_sh | input | 22 | Source current-address shadow |
| cfg_dst_beg_sh | input | 22 | Destination begin-address shadow |
| cfg_dst_cur_sh | input | 22 | Destination current-address shadow |
| cfg_blen | input | 5 | Words per burst minus one |
| cfg_xlen | input | 16 | Bursts per transfer minus one |
| cfg_src_bstep | input | 16 | Source within-burst step, signed |
| cfg_dst_bstep | input | 16 | Destination within-burst step, signed |
| cfg_src_tstep | input | 16 | Source between-burst step, signed |
| cfg_dst_tstep | input | 16 | Destination between-burst step, signed |
| cfg_src_wstep | input | 16 | Source wrap step, signed |
| cfg_dst_wstep | input | 16 | Destination wrap step, signed |
| cfg_src_wsize | input | 16 | Source wrap-counter reload value |
| cfg_dst_wsize | input | 16 | Destination wrap-counter reload value |
| cfg_oneshot | input | 1 | One trigger runs the whole transfer |
| cfg_cont | input | 1 | Re-arm automatically at the end of a transfer |
| cfg_irq_at_end | input | 1 | 1: interrupt at end of transfer; 0: at its first launch |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 22 | Source word address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 22 | Destination word address |
| mem_wr_data | output | 16 | Write data |
| busy | output | 1 | A burst is in progress |
| run | output | 1 | Channel armed or transferring |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume four things about the environment:

- the configuration inputs do not change while `run` is 1;
- the memory returns read data exactly one cycle after `mem_rd_en`;
- `trig` and `start` are single-cycle pulses;
- `start` is only raised while the channel is idle.

The stimulus respects all four. Every configuration change is made right after a reset, before the start pulse. Each pulse is driven for one cycle on the falling edge. The bench memory answers every read on the following rising edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_RD    = 2'd2,
        S_WR    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dma_side_addr.sv
module dma_side_addr #(
    parameter int ADDR_W = 22,
    parameter int STEP_W = 16,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              word_adv,
    input  logic              burst_adv,
    input  logic [ADDR_W-1:0] beg_sh,
    input  logic [ADDR_W-1:0] cur_sh,
    input  logic [STEP_W-1:0] bstep,
    input  logic [STEP_W-1:0] tstep,
    input  logic [STEP_W-1:0] wstep,
    input  logic [WRAP_W-1:0] wsize,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int EXT_W = ADDR_W - STEP_W;

    function automatic logic [ADDR_W-1:0] sext(input logic [STEP_W-1:0] s);
        return {{EXT_W{s[STEP_W-1]}}, s};
    endfunction

    logic [ADDR_W-1:0] beg_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] beg_nx;
    logic [WRAP_W-1:0] wcnt_q;
    logic              wrap_hit;

    assign beg_nx   = beg_q + sext(wstep);
    assign wrap_hit = (wcnt_q == '0);
    assign cur_addr = cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beg_q  <= '0;
            cur_q  <= '0;
            wcnt_q <= '0;
        end else if (load) begin
            beg_q  <= beg_sh;
            cur_q  <= cur_sh;
            wcnt_q <= wsize;
        end else if (word_adv) begin
            cur_q <= cur_q + sext(bstep);
        end else if (burst_adv) begin
            if (wrap_hit) begin
                beg_q  <= beg_nx;
                cur_q  <= beg_nx;
                wcnt_q <= wsize;
            end else begin
                cur_q  <= cur_q + sext(tstep);
                wcnt_q <= wcnt_q - WRAP_W'(1);
            end
        end
    end

endmodule

// File: rtl/dma_burst_cnt.sv
module dma_burst_cnt #(
    parameter int BLEN_W = 5,
    parameter int XLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              word_adv,
    input  logic              burst_adv,
    input  logic [BLEN_W-1:0] blen,
    input  logic [XLEN_W-1:0] xlen,
    output logic              last_word,
    output logic              last_burst,
    output logic              first_burst
);
    logic [BLEN_W-1:0] wcnt_q;
    logic [XLEN_W-1:0] bcnt_q;
    logic              first_q;

    assign last_word   = (wcnt_q == '0);
    assign last_burst  = (bcnt_q == '0);
    assign first_burst = first_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            bcnt_q  <= '0;
            first_q <= 1'b0;
        end else if (load) begin
            wcnt_q  <= blen;
            bcnt_q  <= xlen;
            first_q <= 1'b1;
        end else if (word_adv) begin
            wcnt_q <= wcnt_q - BLEN_W'(1);
        end else if (burst_adv) begin
            wcnt_q  <= blen;
            bcnt_q  <= bcnt_q - XLEN_W'(1);
            first_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int STEP_W = 16,
    parameter int BLEN_W = 5,
    parameter int XLEN_W = 16,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              trig,
    input  logic [ADDR_W-1:0] cfg_src_beg_sh,
    input  logic [ADDR_W-1:0] cfg_src_cur_sh,
    input  logic [ADDR_W-1:0] cfg_dst_beg_sh,
    input  logic [ADDR_W-1:0] cfg_dst_cur_sh,
    input  logic [BLEN_W-1:0] cfg_blen,
    input  logic [XLEN_W-1:0] cfg_xlen,
    input  logic [STEP_W-1:0] cfg_src_bstep,
    input  logic [STEP_W-1:0] cfg_dst_bstep,
    input  logic [STEP_W-1:0] cfg_src_tstep,
    input  logic [STEP_W-1:0] cfg_dst_tstep,
    input  logic [STEP_W-1:0] cfg_src_wstep,
    input  logic [STEP_W-1:0] cfg_dst_wstep,
    input  logic [WRAP_W-1:0] cfg_src_wsize,
    input  logic [WRAP_W-1:0] cfg_dst_wsize,
    input  logic              cfg_oneshot,
    input  logic              cfg_cont,
    input  logic              cfg_irq_at_end,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              busy,
    output logic              run,
    output logic              irq
);
    import dma_seq_pkg::*;

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic              load;
    logic              word_adv;
    logic              burst_adv;
    logic              launch;
    logic              pend_q;
    logic              irq_q;
    logic              word_last;
    logic              burst_last;
    logic              burst_first;
    logic              xfer_end;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;

    // The two sides share one address generator design.
    dma_side_addr #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .WRAP_W(WRAP_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word_adv (word_adv),
        .burst_adv(burst_adv),
        .beg_sh   (cfg_src_beg_sh),
        .cur_sh   (cfg_src_cur_sh),
        .bstep    (cfg_src_bstep),
        .tstep    (cfg_src_tstep),
        .wstep    (cfg_src_wstep),
        .wsize    (cfg_src_wsize),
        .cur_addr (src_addr)
    );

    dma_side_addr #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .WRAP_W(WRAP_W)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word_adv (word_adv),
        .burst_adv(burst_adv),
        .beg_sh   (cfg_dst_beg_sh),
        .cur_sh   (cfg_dst_cur_sh),
        .bstep    (cfg_dst_bstep),
        .tstep    (cfg_dst_tstep),
        .wstep    (cfg_dst_wstep),
        .wsize    (cfg_dst_wsize),
        .cur_addr (dst_addr)
    );

    dma_burst_cnt #(.BLEN_W(BLEN_W), .XLEN_W(XLEN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .word_adv   (word_adv),
        .burst_adv  (burst_adv),
        .blen       (cfg_blen),
        .xlen       (cfg_xlen),
        .last_word  (word_last),
        .last_burst (burst_last),
        .first_burst(burst_first)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and the strobes to the datapath.
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        word_adv  = 1'b0;
        burst_adv = 1'b0;
        launch    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = S_ARMED;
                end
            end
            S_ARMED: begin
                if (trig || pend_q) begin
                    launch  = 1'b1;
                    state_d = S_RD;
                end
            end
            S_RD: begin
                state_d = S_WR;
            end
            S_WR: begin
                if (!word_last) begin
                    word_adv = 1'b1;
                    state_d  = S_RD;
                end else if (!burst_last) begin
                    burst_adv = 1'b1;
                    state_d   = cfg_oneshot ? S_RD : S_ARMED;
                end else if (cfg_cont) begin
                    load    = 1'b1;
                    state_d = S_ARMED;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign xfer_end = (state_q == S_WR) && word_last && burst_last;

    // Pending trigger flag and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (state_q == S_IDLE || launch) begin
                pend_q <= 1'b0;
            end else if (trig && (state_q == S_RD || state_q == S_WR)) begin
                pend_q <= 1'b1;
            end
            irq_q <= cfg_irq_at_end ? xfer_end : (launch && burst_first);
        end
    end

    // Outputs.
    always_comb begin
        mem_rd_en   = (state_q == S_RD);
        mem_wr_en   = (state_q == S_WR);
        mem_rd_addr = src_addr;
        mem_wr_addr = dst_addr;
        mem_wr_data = mem_rd_data;
        busy        = (state_q == S_RD) || (state_q == S_WR);
        run         = (state_q != S_IDLE);
        irq         = irq_q;
    end

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
    parameter int ADDR_W = 22,
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [STEP_W-1:0] cfg_src_bstep,
    input logic [STEP_W-1:0] cfg_dst_bstep,
    input logic              word_last,
    input logic              busy,
    input logic              run,
    input logic              irq
);
    function automatic logic [ADDR_W-1:0] sx(input logic [STEP_W-1:0] s);
        return {{(ADDR_W-STEP_W){s[STEP_W-1]}}, s};
    endfunction

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_burst_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !word_last) |=>
            (mem_rd_addr == $past(mem_rd_addr) + sx(cfg_src_bstep)) &&
            (mem_wr_addr == $past(mem_wr_addr) + sx(cfg_dst_bstep)));

    p_busy_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!busy && !mem_rd_en && !mem_wr_en));

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_wr_addr  (mem_wr_addr),
    .cfg_src_bstep(cfg_src_bstep),
    .cfg_dst_bstep(cfg_dst_bstep),
    .word_last    (word_last),
    .busy         (busy),
    .run          (run),
    .irq          (irq)
);

// File: tb/dma_addr_seq_bench.sv
`timescale 1ns/1ps
module dma_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        trig = 1'b0;
    logic [21:0] src_beg, src_cur, dst_beg, dst_cur;
    logic [4:0]  blen;
    logic [15:0] xlen;
    logic [15:0] sbs, dbs, sts, dts, sws, dws, swz, dwz;
    logic        oneshot, cont, irq_end;
    logic        mem_rd_en, mem_wr_en, busy, run, irq;
    logic [21:0] mem_rd_addr, mem_wr_addr;
    logic [15:0] mem_rd_data = '0;
    logic [15:0] mem_wr_data;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int irq_cnt = 0;
    bit prev_wr = 0;
    bit done = 0;
    logic [21:0] last_wr_addr = '0;
    logic [21:0] q_addr[$];
    logic [15:0] q_data[$];

    always #4 clk = ~clk;

    dma_addr_seq u_dma_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .trig(trig),
        .cfg_src_beg_sh(src_beg), .cfg_src_cur_sh(src_cur),
        .cfg_dst_beg_sh(dst_beg), .cfg_dst_cur_sh(dst_cur),
        .cfg_blen(blen), .cfg_xlen(xlen),
        .cfg_src_bstep(sbs), .cfg_dst_bstep(dbs),
        .cfg_src_tstep(sts), .cfg_dst_tstep(dts),
        .cfg_src_wstep(sws), .cfg_dst_wstep(dws),
        .cfg_src_wsize(swz), .cfg_dst_wsize(dwz),
        .cfg_oneshot(oneshot), .cfg_cont(cont), .cfg_irq_at_end(irq_end),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .run(run), .irq(irq)
    );

    function automatic logic [15:0] mem_word(input logic [21:0] a);
        return a[15:0] ^ {10'h0, a[21:16]} ^ 16'hC3A5;
    endfunction

    // Memory with one cycle of read latency.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: expected write addresses and data, in order.
    task automatic model(input int ntr);
        for (int t = 0; t < ntr; t++) begin
            logic [21:0] sb, sc, db, dc;
            int sw, dw;
            sb = src_beg; sc = src_cur; db = dst_beg; dc = dst_cur;
            sw = int'(swz); dw = int'(dwz);
            for (int b = 0; b <= int'(xlen); b++) begin
                for (int w = 0; w <= int'(blen); w++) begin
                    q_addr.push_back(dc);
                    q_data.push_back(mem_word(sc));
                    if (w < int'(blen)) begin
                        sc = sc + 22'(int'($signed(sbs)));
                        dc = dc + 22'(int'($signed(dbs)));
                    end
                end
                if (b < int'(xlen)) begin
                    if (sw == 0) begin
                        sb = sb + 22'(int'($signed(sws))); sc = sb; sw = int'(swz);
                    end else begin
                        sc = sc + 22'(int'($signed(sts))); sw--;
                    end
                    if (dw == 0) begin
                        db = db + 22'(int'($signed(dws))); dc = db; dw = int'(dwz);
                    end else begin
                        dc = dc + 22'(int'($signed(dts))); dw--;
                    end
                end
            end
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr_en) begin
                wr_cnt++;
                last_wr_addr = mem_wr_addr;
                if (q_addr.size() == 0) begin
                    chk(0, "R6 unexpected write", longint'(mem_wr_addr), 0);
                end else begin
                    logic [21:0] ea;
                    logic [15:0] ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    chk(mem_wr_addr == ea, "R3 R4 R5 R11 write address", longint'(mem_wr_addr), longint'(ea));
                    chk(mem_wr_data == ed, "R2 write data", longint'(mem_wr_data), longint'(ed));
                end
            end
            if (irq) begin
                irq_cnt++;
                if (irq_end)
                    chk(prev_wr && q_addr.size() == 0, "R9 irq after final write", longint'(prev_wr), 1);
            end
            prev_wr = mem_wr_en;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; start = 1'b0; trig = 1'b0;
        repeat (3) @(negedge clk);
        q_addr.delete(); q_data.delete();
        irq_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic trig_wait(input int n);
        pulse_trig();
        repeat (n) @(negedge clk);
    endtask

    task automatic plain_cfg();
        src_beg = 22'h100; src_cur = 22'h100; dst_beg = 22'h2000; dst_cur = 22'h2000;
        blen = 5'd0; xlen = 16'd3;
        sbs = 16'd0; dbs = 16'd0; sts = 16'd1; dts = 16'd1;
        sws = 16'd0; dws = 16'd0; swz = 16'd15; dwz = 16'd3;
        oneshot = 0; cont = 0; irq_end = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int w0;
        plain_cfg();
        do_reset();
        @(negedge clk);
        // R12: reset state
        chk(!run && !busy && !irq && !mem_rd_en && !mem_wr_en, "R12 reset outputs quiet",
            longint'({run, busy, irq, mem_rd_en, mem_wr_en}), 0);

        // One word per burst, four bursts, interrupt at first launch.
        model(1);
        pulse_start();
        chk(run == 1'b1, "R1 run after start", longint'(run), 1);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R1 no burst without trigger", longint'(busy), 0);
        for (int i = 0; i < 4; i++) trig_wait(8);
        chk(run == 1'b0, "R6 run cleared at end", longint'(run), 0);
        chk(q_addr.size() == 0, "R2 all words moved", longint'(q_addr.size()), 0);
        chk(irq_cnt == 1, "R9 start-mode irq count", longint'(irq_cnt), 1);
        w0 = wr_cnt;
        trig_wait(10);
        chk(wr_cnt == w0, "R6 trigger ignored when idle", longint'(wr_cnt - w0), 0);

        // Multi-word bursts, signed steps, wraps on both sides.
        do_reset();
        src_beg = 22'h1000; src_cur = 22'h1004; dst_beg = 22'h3000; dst_cur = 22'h3000;
        blen = 5'd2; xlen = 16'd4;
        sbs = 16'd2; dbs = 16'hFFFF; sts = 16'd16; dts = 16'd5;
        swz = 16'd1; sws = 16'h0100; dwz = 16'd0; dws = 16'hFFFD;
        irq_end = 1;
        model(1);
        pulse_start();
        w0 = wr_cnt;
        trig_wait(12);
        chk(wr_cnt - w0 == 3, "R2 one burst per trigger", longint'(wr_cnt - w0), 3);
        for (int i = 0; i < 4; i++) trig_wait(12);
        chk(q_addr.size() == 0, "R5 wrap sequence complete", longint'(q_addr.size()), 0);
        chk(irq_cnt == 1, "R9 end-mode irq count", longint'(irq_cnt), 1);
        chk(run == 1'b0, "R6 run cleared", longint'(run), 0);

        // Triggers during a burst collapse to one pending burst.
        do_reset();
        plain_cfg();
        blen = 5'd3; sbs = 16'd1; dbs = 16'd1; irq_end = 1;
        model(1);
        pulse_start();
        w0 = wr_cnt;
        pulse_trig();
        pulse_trig();
        pulse_trig();
        repeat (30) @(negedge clk);
        chk(wr_cnt - w0 == 8, "R8 pending collapses to one burst", longint'(wr_cnt - w0), 8);
        chk(run == 1'b1, "R8 still running", longint'(run), 1);
        trig_wait(12);
        trig_wait(12);
        chk(run == 1'b0 && q_addr.size() == 0, "R6 transfer done", longint'(q_addr.size()), 0);

        // Continuous mode re-arms from the shadows.
        do_reset();
        plain_cfg();
        blen = 5'd1; xlen = 16'd1; sbs = 16'd3; dbs = 16'd2; cont = 1;
        model(2);
        pulse_start();
        for (int i = 0; i < 4; i++) trig_wait(10);
        chk(run == 1'b1, "R7 run kept in continuous mode", longint'(run), 1);
        chk(q_addr.size() == 0, "R7 second transfer from shadows", longint'(q_addr.size()), 0);
        chk(irq_cnt == 2, "R9 one irq per transfer", longint'(irq_cnt), 2);

        // One-shot: a single trigger runs all bursts.
        do_reset();
        plain_cfg();
        blen = 5'd1; xlen = 16'd3; oneshot = 1; irq_end = 1;
        model(1);
        pulse_start();
        w0 = wr_cnt;
        trig_wait(40);
        chk(wr_cnt - w0 == 8, "R10 all bursts from one trigger", longint'(wr_cnt - w0), 8);
        chk(run == 1'b0, "R10 run cleared", longint'(run), 0);
        chk(irq_cnt == 1, "R9 one-shot end irq", longint'(irq_cnt), 1);

        // Address wraparound at the 22-bit boundary.
        do_reset();
        plain_cfg();
        src_beg = 22'h3FFFFE; src_cur = 22'h3FFFFE; dst_beg = 22'h0; dst_cur = 22'h0;
        xlen = 16'd2; sts = 16'd2; dts = 16'hFFFF; swz = 16'd100; dwz = 16'd100;
        model(1);
        pulse_start();
        for (int i = 0; i < 3; i++) trig_wait(8);
        chk(last_wr_addr == 22'h3FFFFE, "R11 destination wraps below zero",
            longint'(last_wr_addr), longint'(22'h3FFFFE));
        chk(q_addr.size() == 0, "R11 all words moved", longint'(q_addr.size()), 0);

        finish_run();
    end
endmodule